// File: doc/BRIEF.md
# Duty-Cycled Receive Wake Sequencer

This block runs the discontinuous-receive cycle of a low-power radio receiver. When duty-cycled mode is enabled it steps through three countdowns in a fixed order. The first is an off period. The second is a host-CPU recovery period, during which the block pulls a shared open-drain wake line low so the host can power up. The third is an RF settle period, during which the analog sections selected by software are switched on, except the two peak detectors. Once settling ends, every selected section is on, a one-cycle settled pulse is raised, and the block holds the receive phase.

A small register file, written over a 4-bit address / 8-bit data strobe bus, holds the section enables, the mode and prescaler bits, and the lengths of the three countdowns. The block has no timebase of its own. It counts single-cycle tick enables supplied from outside. The off and settle countdowns use a base tick, and the off countdown can be slowed by a prescaler. The CPU-recovery countdown uses a separate coarse tick (nominally 120 µs), so its duration is the register value times that period.

Top module: `drx_wake_seq`

## Requirements
- R1: Writes with `wr_en` high update the registers as follows; writes to any other address (2, 3, 9 to 15) change nothing:

  | Address | Register |
  |---|---|
  | 0 | section enables |
  | 1 | mode: bit 0 = duty-cycle enable, bits 2:1 = off prescaler select |
  | 4 | off count, high byte |
  | 5 | off count, low byte |
  | 6 | CPU recovery count |
  | 7 | settle count, high byte |
  | 8 | settle count, low byte |

- R2: After reset the block is idle. `wake_drv_low`, `sect_en`, `settled` and `cfg_err` are all 0. Every register is 0, and the CPU recovery register counts as not yet written.
- R3: While duty-cycle mode is enabled and address 6 has never been written, `cfg_err` is high and no sequence starts. Writing address 6 (any value, zero included) clears `cfg_err`, and the off period then begins.
- R4: The off period lasts max(N,1) prescaled ticks, where N is the 16-bit value {addr4, addr5}. Prescaler select values 0, 1, 2 and 3 make one prescaled tick from 1, 4, 16 and 64 base ticks. During the off period the wake line is released and `sect_en` is 0.
- R5: When the off period expires, `wake_drv_low` goes high. It stays high for max(N,1) `cpu_tick` pulses, where N is the address 6 value, and base ticks do not shorten it. `sect_en` is 0 throughout.
- R6: The settle period follows the CPU period. It lasts max(N,1) base ticks, where N is {addr7, addr8}. During settling, `sect_en` equals section-enable bits 7:1, with the peak-detector bits (enable bits 3 and 1, which are `sect_en` bits 2 and 0) forced to 0.
- R7: When settling ends, `sect_en` equals section-enable bits 7:1 unmasked. In the same cycle `settled` is high for exactly one cycle, and the receive phase holds.
- R8: A `restart` pulse in the receive phase starts a new off period. `sect_en` returns to 0 and the off countdown reloads.
- R9: Clearing the duty-cycle enable bit returns the block to idle from any phase within two cycles of the write. The wake line is released and `sect_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| base_tick | input | 1 | Base tick enable for the off and settle countdowns |
| cpu_tick | input | 1 | Coarse tick enable for the CPU recovery countdown |
| restart | input | 1 | Requests a new off period from the receive phase |
| wake_drv_low | output | 1 | 1 = drive the open-drain wake line low |
| sect_en | output | 7 | Analog section enables (section-enable bits 7:1) |
| settled | output | 1 | One-cycle pulse when settling completes |
| cfg_err | output | 1 | Duty-cycle mode requested before the CPU count was written |

## Verification
The hardest state to reach is the exact prescaled expiry at the largest ratio. It takes 64 base ticks per off count, and a high-byte off value turns the off phase into hundreds of base ticks. The bench drives tick pulses one at a time and samples the wake line one tick before and exactly at the expected expiry, for each prescaler setting it uses. The other hard case is clearing the mode in the middle of the CPU phase, while the wake line is held low. The bench reaches it by writing the mode register between CPU ticks, after a zero-length off period reached through `restart`.

// File: rtl/drx_pkg.sv
package drx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_OFF    = 3'd1,
      PH_CPU    = 3'd2,
      PH_SETTLE = 3'd3,
      PH_RX     = 3'd4
   } phase_e;

   // register addresses
   localparam int ADR_PWR    = 0;
   localparam int ADR_MODE   = 1;
   localparam int ADR_OFF_HI = 4;
   localparam int ADR_OFF_LO = 5;
   localparam int ADR_CPU    = 6;
   localparam int ADR_SET_HI = 7;
   localparam int ADR_SET_LO = 8;

   // section-enable bit positions of the two peak detectors
   localparam int PWR_FSK_PEAK = 3;
   localparam int PWR_ASK_PEAK = 1;

endpackage

// File: rtl/drx_regfile.sv
module drx_regfile
   import drx_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int PS_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     pwr_q,
   output logic                  duty_on,
   output logic [PS_BITS-1:0]    ps_sel,
   output logic [2*DATA_W-1:0]   off_val,
   output logic [DATA_W-1:0]     cpu_val,
   output logic [2*DATA_W-1:0]   set_val,
   output logic                  cpu_ok
);

   localparam int MODE_W = PS_BITS + 1;

   logic [MODE_W-1:0] mode_q;
   logic [DATA_W-1:0] off_hi_q, off_lo_q, set_hi_q, set_lo_q, cpu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q    <= '0;
         mode_q   <= '0;
         off_hi_q <= '0;
         off_lo_q <= '0;
         cpu_q    <= '0;
         set_hi_q <= '0;
         set_lo_q <= '0;
         cpu_ok   <= 1'b0;
      end else if (wr_en) begin
         case (int'(wr_addr))
            ADR_PWR:    pwr_q    <= wr_data;
            ADR_MODE:   mode_q   <= wr_data[MODE_W-1:0];
            ADR_OFF_HI: off_hi_q <= wr_data;
            ADR_OFF_LO: off_lo_q <= wr_data;
            ADR_CPU: begin
               cpu_q  <= wr_data;
               cpu_ok <= 1'b1;
            end
            ADR_SET_HI: set_hi_q <= wr_data;
            ADR_SET_LO: set_lo_q <= wr_data;
            default: ;
         endcase
      end
   end

   assign duty_on = mode_q[0];
   assign ps_sel  = mode_q[MODE_W-1:1];
   assign off_val = {off_hi_q, off_lo_q};
   assign set_val = {set_hi_q, set_lo_q};
   assign cpu_val = cpu_q;

endmodule

// File: rtl/drx_prescaler.sv
module drx_prescaler #(
   parameter int PS_BITS = 2,
   parameter int PS_STEP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               base_tick,
   input  logic [PS_BITS-1:0] sel,
   output logic               tick_out
);

   generate
      if (PS_STEP == 0) begin : g_bypass
         assign tick_out = base_tick;
      end else begin : g_div
         localparam int PCW = PS_STEP * ((1 << PS_BITS) - 1);

         logic [PCW-1:0] pcnt;
         logic [PCW:0]   lim;
         logic           hit;

         always_comb begin
            lim = ((PCW+1)'(1) << (PS_STEP * int'(sel))) - (PCW+1)'(1);
            hit = (pcnt == lim[PCW-1:0]);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pcnt <= '0;
            else if (clear)     pcnt <= '0;
            else if (base_tick) pcnt <= hit ? '0 : pcnt + PCW'(1);
         end

         assign tick_out = base_tick && hit;
      end
   endgenerate

endmodule

// File: rtl/drx_countdown.sv
module drx_countdown #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         expire
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (tick) cnt <= cnt - W'(1);
   end

   // a value of 0 or 1 both end on the next tick
   assign expire = tick && (cnt <= W'(1));

endmodule

// File: rtl/drx_seq_fsm.sv
module drx_seq_fsm
   import drx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   duty_on,
   input  logic   cpu_ok,
   input  logic   restart,
   input  logic   off_exp,
   input  logic   cpu_exp,
   input  logic   set_exp,
   output phase_e phase,
   output logic   load_off,
   output logic   load_cpu,
   output logic   load_set,
   output logic   settled
);

   phase_e nxt;

   always_comb begin
      nxt      = phase;
      load_off = 1'b0;
      load_cpu = 1'b0;
      load_set = 1'b0;
      if (!duty_on) begin
         nxt = PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE:   if (cpu_ok)  begin nxt = PH_OFF;    load_off = 1'b1; end
            PH_OFF:    if (off_exp) begin nxt = PH_CPU;    load_cpu = 1'b1; end
            PH_CPU:    if (cpu_exp) begin nxt = PH_SETTLE; load_set = 1'b1; end
            PH_SETTLE: if (set_exp)       nxt = PH_RX;
            PH_RX:     if (restart) begin nxt = PH_OFF;    load_off = 1'b1; end
            default:                      nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         settled <= 1'b0;
      end else begin
         phase   <= nxt;
         settled <= (phase == PH_SETTLE) && (nxt == PH_RX);
      end
   end

endmodule

// File: rtl/drx_wake_seq.sv
module drx_wake_seq
   import drx_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int OFF_W   = 16,
   parameter int CPU_W   = 8,
   parameter int SET_W   = 16,
   parameter int PS_BITS = 2,
   parameter int PS_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              base_tick,
   input  logic              cpu_tick,
   input  logic              restart,
   output logic              wake_drv_low,
   output logic [DATA_W-2:0] sect_en,
   output logic              settled,
   output logic              cfg_err
);

   localparam int SECT_W = DATA_W - 1;
   localparam logic [SECT_W-1:0] PEAK_MASK =
      (SECT_W'(1) << (PWR_FSK_PEAK - 1)) | (SECT_W'(1) << (PWR_ASK_PEAK - 1));

   generate
      if (DATA_W < 8)                begin : g_chk_data $error("DATA_W must cover the section map"); end
      if (ADDR_W < 4)                begin : g_chk_addr $error("ADDR_W must reach address 8"); end
      if (OFF_W != 2 * DATA_W)       begin : g_chk_off  $error("OFF_W must be two data bytes"); end
      if (SET_W != 2 * DATA_W)       begin : g_chk_set  $error("SET_W must be two data bytes"); end
      if (CPU_W != DATA_W)           begin : g_chk_cpu  $error("CPU_W must be one data byte"); end
      if (PS_BITS < 1 || PS_BITS + 1 > DATA_W)
                                     begin : g_chk_ps   $error("PS_BITS out of range"); end
   endgenerate

   logic [DATA_W-1:0]  pwr_q;
   logic               duty_on, cpu_ok;
   logic [PS_BITS-1:0] ps_sel;
   logic [OFF_W-1:0]   off_val;
   logic [CPU_W-1:0]   cpu_val;
   logic [SET_W-1:0]   set_val;
   logic               pres_tick;
   logic               off_exp, cpu_exp, set_exp;
   logic               load_off, load_cpu, load_set;
   phase_e             phase;

   drx_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PS_BITS(PS_BITS)) u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .pwr_q, .duty_on, .ps_sel, .off_val, .cpu_val, .set_val, .cpu_ok
   );

   drx_prescaler #(.PS_BITS(PS_BITS), .PS_STEP(PS_STEP)) u_pres (
      .clk, .rst_n, .clear(load_off), .base_tick, .sel(ps_sel), .tick_out(pres_tick)
   );

   drx_countdown #(.W(OFF_W)) u_off (
      .clk, .rst_n, .load(load_off), .load_val(off_val),
      .tick(pres_tick && (phase == PH_OFF)), .expire(off_exp)
   );

   drx_countdown #(.W(CPU_W)) u_cpu (
      .clk, .rst_n, .load(load_cpu), .load_val(cpu_val),
      .tick(cpu_tick && (phase == PH_CPU)), .expire(cpu_exp)
   );

   drx_countdown #(.W(SET_W)) u_set (
      .clk, .rst_n, .load(load_set), .load_val(set_val),
      .tick(base_tick && (phase == PH_SETTLE)), .expire(set_exp)
   );

   drx_seq_fsm u_fsm (
      .clk, .rst_n, .duty_on, .cpu_ok, .restart,
      .off_exp, .cpu_exp, .set_exp,
      .phase, .load_off, .load_cpu, .load_set, .settled
   );

   always_comb begin
      case (phase)
         PH_SETTLE: sect_en = pwr_q[DATA_W-1:1] & ~PEAK_MASK;
         PH_RX:     sect_en = pwr_q[DATA_W-1:1];
         default:   sect_en = '0;
      endcase
   end

   assign wake_drv_low = (phase == PH_CPU);
   assign cfg_err      = duty_on && !cpu_ok;

endmodule

// File: rtl/drx_wake_seq_chk.sv
module drx_wake_seq_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              cpu_tick,
   input logic              duty_on,
   input logic [DATA_W-1:0] pwr_q,
   input logic              wake_drv_low,
   input logic [DATA_W-2:0] sect_en,
   input logic              settled,
   input logic              cfg_err
);

   // R1: writes to addresses outside the map leave the section enables alone
   a_r1_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (int'(wr_addr) == 2 || int'(wr_addr) == 3 || int'(wr_addr) > 8) |=> $stable(pwr_q));

   // R3: an unwritten CPU count keeps every output quiet
   a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!wake_drv_low && sect_en == '0 && !settled));

   // R5: no analog section is on while the host is being woken
   a_r5_cpu_dark: assert property (@(posedge clk) disable iff (!rst_n)
      wake_drv_low |-> sect_en == '0);

   // R5: the wake line holds unless a CPU tick arrives or the mode is cleared
   a_r5_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wake_drv_low && !cpu_tick && duty_on |=> wake_drv_low);

   // R7: settled is a single-cycle pulse with every selected section on
   a_r7_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
      settled |=> !settled);
   a_r7_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> (sect_en == pwr_q[DATA_W-1:1] && !wake_drv_low));

   // R9: two cycles after the mode is cleared the block is idle
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !duty_on && $past(!duty_on) |-> (!wake_drv_low && sect_en == '0));

endmodule

bind drx_wake_seq drx_wake_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cpu_tick(cpu_tick),
   .duty_on(duty_on), .pwr_q(pwr_q), .wake_drv_low(wake_drv_low),
   .sect_en(sect_en), .settled(settled), .cfg_err(cfg_err)
);

// File: tb/sim_drx_wake_seq.sv
`timescale 1ns/1ps
module sim_drx_wake_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       base_tick = 1'b0;
   logic       cpu_tick = 1'b0;
   logic       restart = 1'b0;
   logic       wake_drv_low;
   logic [6:0] sect_en;
   logic       settled;
   logic       cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [7:0] PWR_A  = 8'hB6;
   localparam logic [6:0] FULL_A = PWR_A[7:1];
   localparam logic [6:0] MASK_A = FULL_A & ~7'b000_0101;

   always #2 clk = ~clk;

   drx_wake_seq u0 (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .base_tick, .cpu_tick,
      .restart, .wake_drv_low, .sect_en, .settled, .cfg_err
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      step();
      wr_en   = 1'b0;
   endtask

   task automatic pulse_base(input int n);
      repeat (n) begin
         base_tick = 1'b1;
         step();
         base_tick = 1'b0;
      end
   endtask

   task automatic pulse_cpu(input int n);
      repeat (n) begin
         cpu_tick = 1'b1;
         step();
         cpu_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk("R2 wake after reset", 32'(wake_drv_low), 0);
      chk("R2 sect_en after reset", 32'(sect_en), 0);
      chk("R2 settled after reset", 32'(settled), 0);
      chk("R2 cfg_err after reset", 32'(cfg_err), 0);
   endtask

   task automatic t_error_gate();
      wr(4'h0, PWR_A);
      wr(4'h4, 8'h00);
      wr(4'h5, 8'h03);
      wr(4'h7, 8'h00);
      wr(4'h8, 8'h02);
      wr(4'h1, 8'h01);
      step();
      chk("R3 cfg_err raised", 32'(cfg_err), 1);
      pulse_base(5);
      pulse_cpu(2);
      chk("R3 no wake without cpu count", 32'(wake_drv_low), 0);
      chk("R3 no sections without cpu count", 32'(sect_en), 0);
      wr(4'h6, 8'h02);
      chk("R3 cfg_err cleared by write", 32'(cfg_err), 0);
      step();
   endtask

   task automatic t_full_cycle();
      pulse_base(2);
      chk("R4 off still running", 32'(wake_drv_low), 0);
      chk("R4 sections off in off phase", 32'(sect_en), 0);
      pulse_base(1);
      chk("R5 wake asserted at off expiry", 32'(wake_drv_low), 1);
      pulse_cpu(1);
      pulse_base(3);
      chk("R5 wake held, base ticks ignored", 32'(wake_drv_low), 1);
      chk("R5 sections off during cpu", 32'(sect_en), 0);
      pulse_cpu(1);
      chk("R5 wake released after cpu count", 32'(wake_drv_low), 0);
      chk("R6 peak detectors masked", 32'(sect_en), 32'(MASK_A));
      pulse_base(1);
      chk("R6 settle still running", 32'(sect_en), 32'(MASK_A));
      chk("R7 no early settled", 32'(settled), 0);
      pulse_base(1);
      chk("R7 full enables", 32'(sect_en), 32'(FULL_A));
      chk("R7 settled pulse", 32'(settled), 1);
      step();
      chk("R7 settled one cycle", 32'(settled), 0);
      step(3);
      chk("R7 receive holds", 32'(sect_en), 32'(FULL_A));
   endtask

   task automatic t_ignored();
      wr(4'h2, 8'h00);
      wr(4'hB, 8'h00);
      wr(4'h9, 8'h00);
      wr(4'h3, 8'h00);
      step(2);
      chk("R1 unmapped writes ignored", 32'(sect_en), 32'(FULL_A));
      wr(4'h0, 8'h2A);
      chk("R1 power write visible", 32'(sect_en), 32'h15);
      wr(4'h0, PWR_A);
   endtask

   task automatic t_restart_clear();
      wr(4'h5, 8'h00);
      restart = 1'b1;
      step();
      restart = 1'b0;
      chk("R8 restart leaves receive", 32'(sect_en), 0);
      chk("R8 wake released in off", 32'(wake_drv_low), 0);
      pulse_base(1);
      chk("R4 zero off count ends on first tick", 32'(wake_drv_low), 1);
      pulse_cpu(1);
      wr(4'h1, 8'h00);
      step();
      chk("R9 wake released on clear", 32'(wake_drv_low), 0);
      chk("R9 sections off on clear", 32'(sect_en), 0);
   endtask

   task automatic t_prescale(input logic [7:0] mode, input logic [7:0] hi,
                             input logic [7:0] lo, input int ticks, input string tag);
      wr(4'h4, hi);
      wr(4'h5, lo);
      wr(4'h1, mode);
      step();
      pulse_base(ticks - 1);
      chk({"R4 ", tag, " before expiry"}, 32'(wake_drv_low), 0);
      pulse_base(1);
      chk({"R4 ", tag, " at expiry"}, 32'(wake_drv_low), 1);
      wr(4'h1, 8'h00);
      step();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_error_gate();
      t_full_cycle();
      t_ignored();
      t_restart_clear();
      t_prescale(8'h03, 8'h00, 8'h02, 8,   "ratio 4");
      t_prescale(8'h05, 8'h00, 8'h01, 16,  "ratio 16");
      t_prescale(8'h07, 8'h00, 8'h01, 64,  "ratio 64");
      t_prescale(8'h01, 8'h01, 8'h00, 256, "high byte");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule